// File: doc/BRIEF.md
# Protection FET Driver Control Arbiter

This block decides, on every clock, whether the gate-driver enables for the charge (CHG) and discharge (DSG) protection FETs of a battery pack are asserted. Several sources compete for each driver. Autonomous operation turns both drivers on when nothing prevents it. Host commands can force a driver on or off, but only when the matching permission bit allows it. Protection faults routed to a FET hold that FET off. Sleep mode can shut the CHG driver. A single driver may be switched by an external PWM waveform.

Body-diode protection ranks above all of these. When one FET is conducting and the other is off, current through the off FET's body diode is prevented by turning that FET on.

The decision is made by a fixed priority tree. Both enables are registered. Two status outputs mirror the registered enables so that a status register elsewhere can read them.

Top module: `fet_gate_arbiter`

## Requirements
- R1: After an active-low synchronous reset, `chg_drv`, `dsg_drv`, `stat_chg`, `stat_dsg` and `pwm_err` are 0, the autonomous toggle state is cleared and no driver is in PWM mode.
- R2: With autonomous enable effective (1) and no blocking condition, both drivers turn on. With autonomous enable effective (0), a driver is on only if the host forces it on, or if body-diode protection turns it on.
- R3: A one-cycle `auto_toggle` pulse inverts a stored toggle bit. The effective autonomous enable is `cfg_auto_en` XOR that toggle bit.
- R4: `host_ctrl` bit 3 forces CHG off and bit 2 forces DSG off; these take effect only when `cfg_host_off_ok` is 1. Bit 1 forces CHG on and bit 0 forces DSG on; these take effect only when `cfg_host_on_ok` is 1. A bit value of 0 forces nothing.
- R5: When a driver is forced both on and off by the host, force-off wins.
- R6: A driver is held off when any active fault bit has its mask bit set for that driver (`fault_chg_mask` for CHG, `fault_dsg_mask` for DSG). This overrides both the autonomous enable and host force-on. Active faults whose mask bit is clear have no effect.
- R7: When `cfg_sleep_chg_off` and `sleep_mode` are both 1, CHG is held off and DSG is unaffected. CHG comes back on once `sleep_mode` falls, unless another condition keeps it off.
- R8: With `cfg_bdp_en` = 1, DSG is turned on when `is_charging` is 1 and the rest of the tree would leave CHG on and DSG off. Symmetrically, CHG is turned on when `is_discharging` is 1 and the rest of the tree would leave DSG on and CHG off. This overrides host force-off, faults, sleep and PWM. With `cfg_bdp_en` = 0 it never acts.
- R9: A write of `pwm_req` (bit 0 = DSG, bit 1 = CHG) on `pwm_wr` is accepted only while `cfg_pwm_ok` is 1. A write while it is 0 clears PWM mode. While a driver is in PWM mode and `cfg_pwm_ok` is 1, that driver's enable is its steady decision ANDed with `pwm_wave`.
- R10: At most one driver is in PWM mode. If a driver is in PWM mode, a write that requests the other driver rejects that request, keeps the active driver only if it is still requested, and sets `pwm_err`. A write requesting both while none is active grants DSG and sets `pwm_err`. Every write recomputes `pwm_err`, so a write with no rejection clears it.
- R11: The enables are registered: the outputs after a rising edge reflect the inputs sampled at that edge. `stat_chg` equals `chg_drv` and `stat_dsg` equals `dsg_drv`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_auto_en | input | 1 | Autonomous enable from configuration |
| auto_toggle | input | 1 | Pulse that inverts the autonomous enable |
| cfg_host_on_ok | input | 1 | Permits host force-on bits |
| cfg_host_off_ok | input | 1 | Permits host force-off bits |
| cfg_bdp_en | input | 1 | Enables body-diode protection |
| cfg_sleep_chg_off | input | 1 | Turns CHG off in sleep mode |
| cfg_pwm_ok | input | 1 | Permits PWM mode |
| host_ctrl | input | 4 | Host control: [3] CHG off, [2] DSG off, [1] CHG on, [0] DSG on |
| fault_active | input | NUM_FAULTS | Active protection faults |
| fault_chg_mask | input | NUM_FAULTS | Faults that control CHG |
| fault_dsg_mask | input | NUM_FAULTS | Faults that control DSG |
| is_charging | input | 1 | Pack current in charge direction |
| is_discharging | input | 1 | Pack current in discharge direction |
| sleep_mode | input | 1 | Device is in sleep mode |
| pwm_wr | input | 1 | Write strobe for the PWM request |
| pwm_req | input | 2 | PWM request: [0] DSG, [1] CHG |
| pwm_wave | input | 1 | PWM waveform |
| chg_drv | output | 1 | CHG gate-driver enable |
| dsg_drv | output | 1 | DSG gate-driver enable |
| stat_chg | output | 1 | Status copy of CHG enable |
| stat_dsg | output | 1 | Status copy of DSG enable |
| pwm_err | output | 1 | PWM request rejected on last write |

## Verification
The bench builds the block with `NUM_FAULTS = 5`. This non-power-of-two width keeps single-fault and multi-fault cases frequent under random stimulus. It also gives enough mask variety to hit a fault that is active but routed to neither driver, or to only one driver. Random permission, host, sleep and direction bits regularly produce the cases where body-diode protection outranks a host force-off. Directed sequences drive the PWM exclusivity and error-clearing order that random writes reach only rarely.

// File: rtl/fet_arb_pkg.sv
package fet_arb_pkg;

  localparam int LANE_DSG = 0;
  localparam int LANE_CHG = 1;
  localparam int LANES    = 2;

  typedef struct packed {
    logic       err;
    logic [1:0] act;
  } pwm_upd_t;

  // Steady decision of one driver before body-diode protection and PWM.
  function automatic logic lane_steady(input logic auto_en, input logic host_on,
                                       input logic host_off, input logic fault_hit,
                                       input logic sleep_off);
    return !host_off && !fault_hit && !sleep_off && (host_on || auto_en);
  endfunction

  // Update of the PWM slot on a request write.
  function automatic pwm_upd_t pwm_update(input logic [1:0] cur, input logic [1:0] req,
                                          input logic ok);
    pwm_upd_t r;
    if (!ok) begin
      r = '{err: 1'b0, act: 2'b00};
    end else if (cur != 2'b00) begin
      r = '{err: |(req & ~cur), act: req & cur};
    end else if (req == 2'b11) begin
      r = '{err: 1'b1, act: 2'b01};
    end else begin
      r = '{err: 1'b0, act: req};
    end
    return r;
  endfunction

endpackage

// File: rtl/fet_fault_reduce.sv
module fet_fault_reduce #(
  parameter int NUM_FAULTS = 8
) (
  input  logic [NUM_FAULTS-1:0] fault_active,
  input  logic [NUM_FAULTS-1:0] mask_dsg,
  input  logic [NUM_FAULTS-1:0] mask_chg,
  output logic                  hit_dsg,
  output logic                  hit_chg
);
  logic [NUM_FAULTS-1:0] routed_dsg;
  logic [NUM_FAULTS-1:0] routed_chg;

  for (genvar g = 0; g < NUM_FAULTS; g++) begin : g_route
    assign routed_dsg[g] = fault_active[g] & mask_dsg[g];
    assign routed_chg[g] = fault_active[g] & mask_chg[g];
  end

  assign hit_dsg = |routed_dsg;
  assign hit_chg = |routed_chg;
endmodule

// File: rtl/fet_pwm_slot.sv
module fet_pwm_slot
  import fet_arb_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr,
  input  logic [1:0] req,
  input  logic       ok,
  output logic [1:0] pwm_on,
  output logic       err
);
  logic [1:0] act_q;
  logic       err_q;
  pwm_upd_t   upd;

  assign upd = pwm_update(act_q, req, ok);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act_q <= 2'b00;
      err_q <= 1'b0;
    end else if (wr) begin
      act_q <= upd.act;
      err_q <= upd.err;
    end
  end

  assign pwm_on = act_q & {2{ok}};
  assign err    = err_q;

  a_r10_single_pwm: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(act_q));
  a_r9_pwm_needs_ok: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && !ok) |=> (act_q == 2'b00));
  a_r10_err_only_on_write: assert property (@(posedge clk) disable iff (!rst_n)
    !wr |=> $stable(err_q));
endmodule

// File: rtl/fet_lane.sv
module fet_lane
  import fet_arb_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic auto_en,
  input  logic host_on,
  input  logic host_off,
  input  logic fault_hit,
  input  logic sleep_off,
  input  logic pwm_on,
  input  logic pwm_wave,
  input  logic bdp_force,
  output logic steady,
  output logic drv_q
);
  logic next_drv;

  assign steady   = lane_steady(auto_en, host_on, host_off, fault_hit, sleep_off);
  assign next_drv = bdp_force | (steady & (!pwm_on | pwm_wave));

  always_ff @(posedge clk) begin
    if (!rst_n) drv_q <= 1'b0;
    else        drv_q <= next_drv;
  end

  a_r5_host_off_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (host_off && !bdp_force) |=> !drv_q);
  a_r6_fault_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_hit && !bdp_force) |=> !drv_q);
  a_r7_sleep_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    (sleep_off && !bdp_force) |=> !drv_q);
  a_r8_bdp_turns_on: assert property (@(posedge clk) disable iff (!rst_n)
    bdp_force |=> drv_q);
  a_r9_pwm_low_gates: assert property (@(posedge clk) disable iff (!rst_n)
    (pwm_on && !pwm_wave && !bdp_force) |=> !drv_q);
endmodule

// File: rtl/fet_gate_arbiter.sv
module fet_gate_arbiter
  import fet_arb_pkg::*;
#(
  parameter int NUM_FAULTS = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cfg_auto_en,
  input  logic                  auto_toggle,
  input  logic                  cfg_host_on_ok,
  input  logic                  cfg_host_off_ok,
  input  logic                  cfg_bdp_en,
  input  logic                  cfg_sleep_chg_off,
  input  logic                  cfg_pwm_ok,
  input  logic [3:0]            host_ctrl,
  input  logic [NUM_FAULTS-1:0] fault_active,
  input  logic [NUM_FAULTS-1:0] fault_chg_mask,
  input  logic [NUM_FAULTS-1:0] fault_dsg_mask,
  input  logic                  is_charging,
  input  logic                  is_discharging,
  input  logic                  sleep_mode,
  input  logic                  pwm_wr,
  input  logic [1:0]            pwm_req,
  input  logic                  pwm_wave,
  output logic                  chg_drv,
  output logic                  dsg_drv,
  output logic                  stat_chg,
  output logic                  stat_dsg,
  output logic                  pwm_err
);
  localparam int OFF_BASE = 2;  // host_ctrl[OFF_BASE + lane] forces off

  logic             tog_q;
  logic             auto_eff;
  logic [LANES-1:0] host_on, host_off, fault_hit, sleep_off, pwm_on;
  logic [LANES-1:0] steady, bdp_force, drv_q;

  always_ff @(posedge clk) begin
    if (!rst_n)           tog_q <= 1'b0;
    else if (auto_toggle) tog_q <= ~tog_q;
  end
  assign auto_eff = cfg_auto_en ^ tog_q;

  fet_fault_reduce #(.NUM_FAULTS(NUM_FAULTS)) u_faults (
    .fault_active (fault_active),
    .mask_dsg     (fault_dsg_mask),
    .mask_chg     (fault_chg_mask),
    .hit_dsg      (fault_hit[LANE_DSG]),
    .hit_chg      (fault_hit[LANE_CHG])
  );

  fet_pwm_slot u_pwm (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr     (pwm_wr),
    .req    (pwm_req),
    .ok     (cfg_pwm_ok),
    .pwm_on (pwm_on),
    .err    (pwm_err)
  );

  assign sleep_off[LANE_DSG] = 1'b0;
  assign sleep_off[LANE_CHG] = cfg_sleep_chg_off & sleep_mode;

  // Body diode guard: the idle FET conducts through its diode.
  assign bdp_force[LANE_DSG] = cfg_bdp_en & is_charging &
                               steady[LANE_CHG] & ~steady[LANE_DSG];
  assign bdp_force[LANE_CHG] = cfg_bdp_en & is_discharging &
                               steady[LANE_DSG] & ~steady[LANE_CHG];

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign host_on[l]  = cfg_host_on_ok  & host_ctrl[l];
    assign host_off[l] = cfg_host_off_ok & host_ctrl[OFF_BASE + l];

    fet_lane u_lane (
      .clk       (clk),
      .rst_n     (rst_n),
      .auto_en   (auto_eff),
      .host_on   (host_on[l]),
      .host_off  (host_off[l]),
      .fault_hit (fault_hit[l]),
      .sleep_off (sleep_off[l]),
      .pwm_on    (pwm_on[l]),
      .pwm_wave  (pwm_wave),
      .bdp_force (bdp_force[l]),
      .steady    (steady[l]),
      .drv_q     (drv_q[l])
    );
  end

  assign chg_drv  = drv_q[LANE_CHG];
  assign dsg_drv  = drv_q[LANE_DSG];
  assign stat_chg = drv_q[LANE_CHG];
  assign stat_dsg = drv_q[LANE_DSG];

  a_r3_toggle_flips: assert property (@(posedge clk) disable iff (!rst_n)
    auto_toggle |=> (tog_q != $past(tog_q)));
  a_r8_bdp_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(bdp_force[LANE_DSG] && bdp_force[LANE_CHG]));
  a_r2_idle_off: assert property (@(posedge clk) disable iff (!rst_n)
    (!auto_eff && !host_on[LANE_DSG] && !bdp_force[LANE_DSG]) |=> !dsg_drv);
endmodule

// File: tb/test_fet_gate_arbiter.sv
module test_fet_gate_arbiter;
  localparam int NF = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_auto_en = 0, auto_toggle = 0, cfg_host_on_ok = 0, cfg_host_off_ok = 0;
  logic cfg_bdp_en = 0, cfg_sleep_chg_off = 0, cfg_pwm_ok = 0;
  logic [3:0] host_ctrl = '0;
  logic [NF-1:0] fault_active = '0, fault_chg_mask = '0, fault_dsg_mask = '0;
  logic is_charging = 0, is_discharging = 0, sleep_mode = 0;
  logic pwm_wr = 0, pwm_wave = 0;
  logic [1:0] pwm_req = '0;
  logic chg_drv, dsg_drv, stat_chg, stat_dsg, pwm_err;

  int total = 0, bad = 0;
  bit done = 0;

  // bench model state
  logic m_tog = 0, m_err = 0;
  logic [1:0] m_pwm = '0;
  logic e_chg, e_dsg;

  always #10 clk = ~clk;

  fet_gate_arbiter #(.NUM_FAULTS(NF)) i_fet_gate_arbiter (.*);

  task automatic chk(input string req, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0b exp=%0b t=%0t", req, act, exp, $time);
    end
  endtask

  // Expected enables from the requirement text: {chg, dsg}
  function automatic logic [1:0] expect_drv();
    logic aut, f_c, f_d, on_c, on_d, off_c, off_d, sl, s_c, s_d, b_c, b_d, p_c, p_d;
    aut   = cfg_auto_en ^ m_tog;                             // R3
    f_c   = (fault_active & fault_chg_mask) != 0;            // R6
    f_d   = (fault_active & fault_dsg_mask) != 0;
    on_c  = host_ctrl[1] && cfg_host_on_ok;                  // R4
    on_d  = host_ctrl[0] && cfg_host_on_ok;
    off_c = host_ctrl[3] && cfg_host_off_ok;
    off_d = host_ctrl[2] && cfg_host_off_ok;
    sl    = sleep_mode && cfg_sleep_chg_off;                 // R7
    s_c   = (aut || on_c) && !(off_c || f_c || sl);          // R2 R5
    s_d   = (aut || on_d) && !(off_d || f_d);
    b_d   = cfg_bdp_en && is_charging && s_c && !s_d;        // R8
    b_c   = cfg_bdp_en && is_discharging && s_d && !s_c;
    p_c   = cfg_pwm_ok && m_pwm[1];                          // R9
    p_d   = cfg_pwm_ok && m_pwm[0];
    return {b_c || (s_c && (!p_c || pwm_wave)), b_d || (s_d && (!p_d || pwm_wave))};
  endfunction

  task automatic model_after_edge();
    if (auto_toggle) m_tog = ~m_tog;
    if (pwm_wr) begin
      if (!cfg_pwm_ok) begin m_pwm = 2'b00; m_err = 0; end
      else if (m_pwm == 2'b01) begin m_err = pwm_req[1]; m_pwm = {1'b0, pwm_req[0]}; end
      else if (m_pwm == 2'b10) begin m_err = pwm_req[0]; m_pwm = {pwm_req[1], 1'b0}; end
      else if (pwm_req == 2'b11) begin m_err = 1; m_pwm = 2'b01; end
      else begin m_err = 0; m_pwm = pwm_req; end
    end
  endtask

  // Inputs already set after a falling edge; clock once and compare.
  task automatic step(input string tag);
    logic [1:0] e;
    e = expect_drv();
    @(posedge clk);
    model_after_edge();
    @(negedge clk);
    chk({tag, " R11 chg"}, chg_drv, e[1]);
    chk({tag, " R11 dsg"}, dsg_drv, e[0]);
    chk({tag, " R11 stat_chg"}, stat_chg, chg_drv);
    chk({tag, " R11 stat_dsg"}, stat_dsg, dsg_drv);
    chk({tag, " R10 err"}, pwm_err, m_err);
    auto_toggle = 0;
    pwm_wr = 0;
  endtask

  task automatic clear_inputs();
    cfg_auto_en = 0; cfg_host_on_ok = 0; cfg_host_off_ok = 0; cfg_bdp_en = 0;
    cfg_sleep_chg_off = 0; cfg_pwm_ok = 0; host_ctrl = '0; fault_active = '0;
    fault_chg_mask = '0; fault_dsg_mask = '0; is_charging = 0; is_discharging = 0;
    sleep_mode = 0; pwm_req = '0; pwm_wave = 0;
  endtask

  initial begin
    #(20 * 150000);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd7341));
    // R1 reset
    cfg_auto_en = 1; cfg_pwm_ok = 1; pwm_wr = 1; pwm_req = 2'b11; auto_toggle = 1;
    repeat (3) @(negedge clk);
    chk("R1 chg", chg_drv, 0); chk("R1 dsg", dsg_drv, 0);
    chk("R1 stat_chg", stat_chg, 0); chk("R1 stat_dsg", stat_dsg, 0);
    chk("R1 err", pwm_err, 0);
    pwm_wr = 0; auto_toggle = 0; clear_inputs();
    rst_n = 1;
    step("R1 idle");
    chk("R1 idle off", chg_drv | dsg_drv, 0);

    // R2 autonomous on
    cfg_auto_en = 1; step("R2 auto");
    chk("R2 both on", chg_drv & dsg_drv, 1);
    // R3 toggle inverts
    auto_toggle = 1; step("R3 toggle");
    step("R3 after");
    chk("R3 off after toggle", chg_drv | dsg_drv, 0);
    auto_toggle = 1; step("R3 back"); step("R3 back2");
    chk("R3 on again", chg_drv & dsg_drv, 1);
    // R4 permissions, R5 off wins
    cfg_auto_en = 0; host_ctrl = 4'b0011; step("R4 on no perm");
    chk("R4 on needs perm", chg_drv | dsg_drv, 0);
    cfg_host_on_ok = 1; step("R4 on perm");
    chk("R4 forced on", chg_drv & dsg_drv, 1);
    host_ctrl = 4'b1111; step("R5 no off perm");
    cfg_host_off_ok = 1; step("R5 off wins");
    chk("R5 off wins", chg_drv | dsg_drv, 0);
    host_ctrl = 4'b1011; step("R4 chg only off");
    chk("R4 bit3 chg", chg_drv, 0); chk("R4 dsg kept", dsg_drv, 1);
    // R6 faults
    host_ctrl = 4'b0011; fault_active = 5'b00100; fault_dsg_mask = 5'b00100;
    fault_chg_mask = 5'b01000; step("R6 fault");
    chk("R6 dsg blocked", dsg_drv, 0); chk("R6 chg unmasked", chg_drv, 1);
    // R8 bdp over fault
    cfg_bdp_en = 1; is_charging = 1; step("R8 bdp");
    chk("R8 dsg restored", dsg_drv, 1);
    cfg_bdp_en = 0; step("R8 off");
    chk("R8 disabled", dsg_drv, 0);
    // R7 sleep
    clear_inputs(); cfg_auto_en = 1; cfg_sleep_chg_off = 1; sleep_mode = 1; step("R7 sleep");
    chk("R7 chg off", chg_drv, 0); chk("R7 dsg on", dsg_drv, 1);
    sleep_mode = 0; step("R7 wake");
    chk("R7 chg back", chg_drv, 1);
    // R9/R10 PWM
    clear_inputs(); cfg_auto_en = 1; pwm_wr = 1; pwm_req = 2'b01; step("R9 no ok");
    cfg_pwm_ok = 1; pwm_wr = 1; pwm_req = 2'b01; step("R9 dsg pwm");
    pwm_wave = 0; step("R9 wave low");
    chk("R9 dsg gated", dsg_drv, 0); chk("R9 chg steady", chg_drv, 1);
    pwm_wr = 1; pwm_req = 2'b11; step("R10 reject");
    chk("R10 err set", pwm_err, 1);
    pwm_wr = 1; pwm_req = 2'b00; step("R10 clear");
    chk("R10 err clr", pwm_err, 0);
    pwm_wr = 1; pwm_req = 2'b11; step("R10 both");
    pwm_wave = 0; step("R10 both wave");
    chk("R10 dsg granted", dsg_drv, 0); chk("R10 chg not", chg_drv, 1);

    // Random phase
    clear_inputs();
    for (int i = 0; i < 4000; i++) begin
      cfg_auto_en       = ($urandom % 4) != 0;
      auto_toggle       = ($urandom % 16) == 0;
      cfg_host_on_ok    = $urandom % 2;
      cfg_host_off_ok   = $urandom % 2;
      cfg_bdp_en        = $urandom % 2;
      cfg_sleep_chg_off = $urandom % 2;
      cfg_pwm_ok        = ($urandom % 4) != 0;
      host_ctrl         = 4'($urandom) & 4'($urandom);
      fault_active      = NF'($urandom) & NF'($urandom) & NF'($urandom);
      fault_chg_mask    = NF'($urandom);
      fault_dsg_mask    = NF'($urandom);
      is_charging       = $urandom % 2;
      is_discharging    = !is_charging && ($urandom % 2);
      sleep_mode        = ($urandom % 4) == 0;
      pwm_wr            = ($urandom % 8) == 0;
      pwm_req           = 2'($urandom);
      pwm_wave          = $urandom % 2;
      step("RND");
    end

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule